// File: doc/BRIEF.md
# Completion Ring Manager with One-Shot Arming

This block keeps the state of a set of completion rings that hardware fills and software drains. Each ring has a host base address, a power-of-two size, a producer pointer, a consumer pointer, a count of reserved slots and an arm flag. The enqueue is a two-step operation. First a producer asks for a slot and gets back a status and the host address where its record belongs. Later it commits the slot, and only the commit moves the producer pointer forward.

If the ring is armed when a commit lands, the block raises an event. The event carries the ring number and the event-ring index from that ring's configuration, and the arm flag then drops until software sets it again. Software configures each ring, reads the producer pointer, returns slots by writing the consumer pointer, and rearms the ring through an AXI4-Lite slave port.

Writing the records to host memory is left to the producer, which uses the address returned in the response.

Top module: `cq_ring_manager`

## Requirements
- R1: After reset, all pointers, reservation counts, base addresses, control fields and arm flags are zero. The response, event, write-response and read-data valids are low, and the enqueue-request and commit readies are high.
- R2: A request accepted for a ring that is not full reserves one slot. One cycle later it gives a response with status 0 (OK), the request tag, and the address base + ((producer + reserved) mod 2^log_size) × 32.
- R3: A ring is full when (producer + reserved − consumer) mod 2^16 is at least 2^log_size. Reserved slots that are not yet committed count toward this. A request to a full ring gives status 1 (FULL) and reserves nothing.
- R4: A commit to a ring with at least one reserved slot adds one to its producer pointer and takes one from its reserved count. A commit to a ring with no reserved slot changes nothing. No other action moves the producer pointer.
- R5: A counting commit to an armed ring raises an event one cycle later, with event_eq set to the ring's event index and event_cq set to the ring number, and it clears the arm flag. A commit to an unarmed ring raises no event. A software control write in the same cycle decides the arm flag.
- R6: Register map: each ring has a 32-byte window, with the ring number in address bits [6:5] and the word in bits [4:2]. The words are:
  - word 0: base address.
  - word 1: control, with log_size in bits [3:0], event index in bits [15:8] and arm in bit 31.
  - word 2: producer pointer, read-only; writes to it are ignored.
  - word 3: consumer pointer.
  - all other words read 0.
- R7: Writing the consumer pointer frees slots, so a ring that was full accepts the next request with status OK.
- R8: While resp_valid is high and resp_ready is low, the response holds its value and no new request is accepted.
- R9: While event_valid is high and event_ready is low, the event holds its value and commit_ready is low.
- R10: A write whose byte strobes are not all ones changes no register, and it still gets a write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_axil_awaddr | input | 7 | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response, always OKAY |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 7 | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response, always OKAY |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| enq_queue | input | 2 | Ring addressed by the enqueue request |
| enq_tag | input | 4 | Requester tag echoed in the response |
| enq_valid | input | 1 | Enqueue request valid |
| enq_ready | output | 1 | Enqueue request ready |
| resp_tag | output | 4 | Echoed tag |
| resp_status | output | 2 | 0 = OK, 1 = FULL |
| resp_addr | output | 32 | Host address of the reserved slot |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response ready |
| commit_queue | input | 2 | Ring being committed |
| commit_valid | input | 1 | Commit valid |
| commit_ready | output | 1 | Commit ready |
| event_eq | output | 8 | Event-ring index from the ring's configuration |
| event_cq | output | 2 | Ring that raised the event |
| event_valid | output | 1 | Event valid |
| event_ready | input | 1 | Event ready |

## Verification
The assertions check, on every cycle:
- the producer pointer stays still without a commit;
- a full ring's reserved count is untouched by a rejected request;
- the arm flag is low after an event fires;
- a stalled response, event or read datum holds its value.

Other behaviour needs the bench's reference model and its scenarios:
- the slot address arithmetic and its modular wrap;
- the full threshold with outstanding reservations and an odd consumer value;
- the consumer write that frees slots;
- rearming and repeat events, and the ignored writes to the producer word or with partial strobes.

// File: rtl/cqm_pkg.sv
package cqm_pkg;
   typedef enum logic [1:0] {
      CQ_ST_OK   = 2'd0,
      CQ_ST_FULL = 2'd1
   } cq_status_e;

   localparam logic [2:0] RW_BASE = 3'd0;
   localparam logic [2:0] RW_CTRL = 3'd1;
   localparam logic [2:0] RW_PROD = 3'd2;
   localparam logic [2:0] RW_CONS = 3'd3;

   localparam int LOG_W        = 4;
   localparam int CTRL_EQN_LSB = 8;
   localparam int CTRL_ARM_BIT = 31;
endpackage

// File: rtl/cqm_axil_port.sv
module cqm_axil_port #(
   parameter int AW = 7,
   localparam int WA = AW - 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] awaddr,
   input  logic          awvalid,
   output logic          awready,
   input  logic [31:0]   wdata,
   input  logic [3:0]    wstrb,
   input  logic          wvalid,
   output logic          wready,
   output logic [1:0]    bresp,
   output logic          bvalid,
   input  logic          bready,
   input  logic [AW-1:0] araddr,
   input  logic          arvalid,
   output logic          arready,
   output logic [31:0]   rdata,
   output logic [1:0]    rresp,
   output logic          rvalid,
   input  logic          rready,
   output logic          wr_en,
   output logic [WA-1:0] wr_word_addr,
   output logic [31:0]   wr_data,
   output logic [WA-1:0] rd_word_addr,
   input  logic [31:0]   rd_data
);
   logic wr_go, rd_go;
   logic unused_lsbs;

   assign unused_lsbs  = ^{awaddr[1:0], araddr[1:0]};
   assign wr_go        = awvalid && wvalid && !bvalid;
   assign awready      = wvalid && !bvalid;
   assign wready       = awvalid && !bvalid;
   assign wr_en        = wr_go && (&wstrb);
   assign wr_word_addr = awaddr[AW-1:2];
   assign wr_data      = wdata;
   assign bresp        = 2'b00;

   assign arready      = !rvalid;
   assign rd_go        = arvalid && arready;
   assign rd_word_addr = araddr[AW-1:2];
   assign rresp        = 2'b00;

   always_ff @(posedge clk) begin
      if (rst) begin
         bvalid <= 1'b0;
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         if (wr_go)       bvalid <= 1'b1;
         else if (bready) bvalid <= 1'b0;
         if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_data;
         end else if (rready) begin
            rvalid <= 1'b0;
         end
      end
   end

   a_r6_read_hold: assert property (@(posedge clk) disable iff (rst)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));

   a_r10_bresp_hold: assert property (@(posedge clk) disable iff (rst)
      (bvalid && !bready) |=> bvalid);
endmodule

// File: rtl/cqm_slot.sv
module cqm_slot
   import cqm_pkg::*;
#(
   parameter int PTR_W   = 16,
   parameter int DMA_W   = 32,
   parameter int EQN_W   = 8,
   parameter int REC_LOG = 5,
   localparam int CNT_W  = PTR_W + 1,
   localparam int LOG_MAX = (PTR_W - 1 < (1 << LOG_W) - 1) ? PTR_W - 1 : (1 << LOG_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sw_we,
   input  logic [2:0]       sw_word,
   input  logic [31:0]      sw_data,
   input  logic             enq_take,
   input  logic             cmt_take,
   output logic [DMA_W-1:0] slot_addr,
   output logic             is_full,
   output logic             ev_fire,
   output logic [DMA_W-1:0] base_o,
   output logic [LOG_W-1:0] log_o,
   output logic [EQN_W-1:0] eqn_o,
   output logic             arm_o,
   output logic [PTR_W-1:0] prod_o,
   output logic [PTR_W-1:0] cons_o
);
   localparam logic [LOG_W-1:0] LOG_CAP = LOG_W'(LOG_MAX);

   logic [DMA_W-1:0] base_q;
   logic [LOG_W-1:0] log_q, log_in;
   logic [EQN_W-1:0] eqn_q;
   logic             arm_q;
   logic [PTR_W-1:0] prod_q, cons_q, rsv_q;
   logic [PTR_W-1:0] occ, idx;
   logic [CNT_W-1:0] size_w;
   logic             reserve, retire, ctrl_we;
   logic             unused_data;

   assign unused_data = ^sw_data;
   assign size_w      = CNT_W'(1) << log_q;
   assign occ         = prod_q + rsv_q - cons_q;
   assign is_full     = {1'b0, occ} >= size_w;
   assign reserve     = enq_take && !is_full;
   assign retire      = cmt_take && (rsv_q != '0);
   assign ev_fire     = retire && arm_q;
   assign idx         = (prod_q + rsv_q) & (size_w[PTR_W-1:0] - PTR_W'(1));
   assign slot_addr   = base_q + (DMA_W'(idx) << REC_LOG);
   assign ctrl_we     = sw_we && (sw_word == RW_CTRL);
   assign log_in      = (sw_data[LOG_W-1:0] > LOG_CAP) ? LOG_CAP : sw_data[LOG_W-1:0];

   assign base_o = base_q;
   assign log_o  = log_q;
   assign eqn_o  = eqn_q;
   assign arm_o  = arm_q;
   assign prod_o = prod_q;
   assign cons_o = cons_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         log_q  <= '0;
         eqn_q  <= '0;
         arm_q  <= 1'b0;
         prod_q <= '0;
         cons_q <= '0;
         rsv_q  <= '0;
      end else begin
         rsv_q  <= rsv_q + PTR_W'(reserve) - PTR_W'(retire);
         prod_q <= prod_q + PTR_W'(retire);
         if (ctrl_we)      arm_q <= sw_data[CTRL_ARM_BIT];
         else if (ev_fire) arm_q <= 1'b0;
         if (sw_we) begin
            case (sw_word)
               RW_BASE: base_q <= sw_data[DMA_W-1:0];
               RW_CTRL: begin
                  log_q <= log_in;
                  eqn_q <= sw_data[CTRL_EQN_LSB +: EQN_W];
               end
               RW_CONS: cons_q <= sw_data[PTR_W-1:0];
               default: ;
            endcase
         end
      end
   end

   a_r4_prod_only_on_commit: assert property (@(posedge clk) disable iff (rst)
      !cmt_take |=> $stable(prod_q));

   a_r3_full_reserves_nothing: assert property (@(posedge clk) disable iff (rst)
      (enq_take && is_full && !cmt_take) |=> (rsv_q == $past(rsv_q)));

   a_r5_arm_one_shot: assert property (@(posedge clk) disable iff (rst)
      (ev_fire && !ctrl_we) |=> !arm_q);
endmodule

// File: rtl/cq_ring_manager.sv
module cq_ring_manager
   import cqm_pkg::*;
#(
   parameter int QUEUE_COUNT = 4,
   parameter int PTR_W       = 16,
   parameter int DMA_W       = 32,
   parameter int EQN_W       = 8,
   parameter int TAG_W       = 4,
   parameter int REC_LOG     = 5,
   localparam int QW         = $clog2(QUEUE_COUNT),
   localparam int AXIL_AW    = QW + 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [AXIL_AW-1:0] s_axil_awaddr,
   input  logic               s_axil_awvalid,
   output logic               s_axil_awready,
   input  logic [31:0]        s_axil_wdata,
   input  logic [3:0]         s_axil_wstrb,
   input  logic               s_axil_wvalid,
   output logic               s_axil_wready,
   output logic [1:0]         s_axil_bresp,
   output logic               s_axil_bvalid,
   input  logic               s_axil_bready,
   input  logic [AXIL_AW-1:0] s_axil_araddr,
   input  logic               s_axil_arvalid,
   output logic               s_axil_arready,
   output logic [31:0]        s_axil_rdata,
   output logic [1:0]         s_axil_rresp,
   output logic               s_axil_rvalid,
   input  logic               s_axil_rready,
   input  logic [QW-1:0]      enq_queue,
   input  logic [TAG_W-1:0]   enq_tag,
   input  logic               enq_valid,
   output logic               enq_ready,
   output logic [TAG_W-1:0]   resp_tag,
   output logic [1:0]         resp_status,
   output logic [DMA_W-1:0]   resp_addr,
   output logic               resp_valid,
   input  logic               resp_ready,
   input  logic [QW-1:0]      commit_queue,
   input  logic               commit_valid,
   output logic               commit_ready,
   output logic [EQN_W-1:0]   event_eq,
   output logic [QW-1:0]      event_cq,
   output logic               event_valid,
   input  logic               event_ready
);
   localparam int WA = AXIL_AW - 2;

   if (QUEUE_COUNT < 2 || (1 << QW) != QUEUE_COUNT) begin : g_bad_count
      $error("QUEUE_COUNT must be a power of two of at least 2");
   end
   if (PTR_W < 2 || PTR_W > 32) begin : g_bad_ptr
      $error("PTR_W must lie in 2..32");
   end
   if (DMA_W < 8 || DMA_W > 32) begin : g_bad_dma
      $error("DMA_W must lie in 8..32");
   end
   if (EQN_W < 1 || EQN_W > CTRL_ARM_BIT - CTRL_EQN_LSB) begin : g_bad_eqn
      $error("EQN_W does not fit the control word");
   end

   logic          wr_en;
   logic [WA-1:0] wr_wa, rd_wa;
   logic [31:0]   wr_data, rd_data;
   logic [QW-1:0] wr_q, rd_q;
   logic [2:0]    wr_word, rd_word;

   cqm_axil_port #(.AW(AXIL_AW)) u_axil (
      .clk(clk), .rst(rst),
      .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
      .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid),
      .wready(s_axil_wready), .bresp(s_axil_bresp), .bvalid(s_axil_bvalid),
      .bready(s_axil_bready), .araddr(s_axil_araddr), .arvalid(s_axil_arvalid),
      .arready(s_axil_arready), .rdata(s_axil_rdata), .rresp(s_axil_rresp),
      .rvalid(s_axil_rvalid), .rready(s_axil_rready),
      .wr_en(wr_en), .wr_word_addr(wr_wa), .wr_data(wr_data),
      .rd_word_addr(rd_wa), .rd_data(rd_data)
   );

   assign wr_q    = wr_wa[WA-1 -: QW];
   assign wr_word = wr_wa[2:0];
   assign rd_q    = rd_wa[WA-1 -: QW];
   assign rd_word = rd_wa[2:0];

   logic enq_acc, cmt_acc;
   assign enq_ready    = !resp_valid || resp_ready;
   assign commit_ready = !event_valid || event_ready;
   assign enq_acc      = enq_valid && enq_ready;
   assign cmt_acc      = commit_valid && commit_ready;

   logic [DMA_W-1:0]       s_addr [QUEUE_COUNT];
   logic [DMA_W-1:0]       s_base [QUEUE_COUNT];
   logic [LOG_W-1:0]       s_log  [QUEUE_COUNT];
   logic [EQN_W-1:0]       s_eqn  [QUEUE_COUNT];
   logic [PTR_W-1:0]       s_prod [QUEUE_COUNT];
   logic [PTR_W-1:0]       s_cons [QUEUE_COUNT];
   logic [QUEUE_COUNT-1:0] s_full, s_arm, s_ev;

   for (genvar i = 0; i < QUEUE_COUNT; i++) begin : g_slot
      cqm_slot #(
         .PTR_W(PTR_W), .DMA_W(DMA_W), .EQN_W(EQN_W), .REC_LOG(REC_LOG)
      ) u_slot (
         .clk(clk), .rst(rst),
         .sw_we(wr_en && (wr_q == QW'(i))), .sw_word(wr_word), .sw_data(wr_data),
         .enq_take(enq_acc && (enq_queue == QW'(i))),
         .cmt_take(cmt_acc && (commit_queue == QW'(i))),
         .slot_addr(s_addr[i]), .is_full(s_full[i]), .ev_fire(s_ev[i]),
         .base_o(s_base[i]), .log_o(s_log[i]), .eqn_o(s_eqn[i]), .arm_o(s_arm[i]),
         .prod_o(s_prod[i]), .cons_o(s_cons[i])
      );
   end

   always_comb begin
      rd_data = '0;
      case (rd_word)
         RW_BASE: rd_data = 32'(s_base[rd_q]);
         RW_CTRL: begin
            rd_data[CTRL_ARM_BIT]              = s_arm[rd_q];
            rd_data[CTRL_EQN_LSB +: EQN_W]     = s_eqn[rd_q];
            rd_data[LOG_W-1:0]                 = s_log[rd_q];
         end
         RW_PROD: rd_data = 32'(s_prod[rd_q]);
         RW_CONS: rd_data = 32'(s_cons[rd_q]);
         default: rd_data = '0;
      endcase
   end

   cq_status_e resp_st_q;
   assign resp_status = resp_st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid  <= 1'b0;
         resp_tag    <= '0;
         resp_st_q   <= CQ_ST_OK;
         resp_addr   <= '0;
         event_valid <= 1'b0;
         event_eq    <= '0;
         event_cq    <= '0;
      end else begin
         if (enq_acc) begin
            resp_valid <= 1'b1;
            resp_tag   <= enq_tag;
            resp_st_q  <= s_full[enq_queue] ? CQ_ST_FULL : CQ_ST_OK;
            resp_addr  <= s_addr[enq_queue];
         end else if (resp_ready) begin
            resp_valid <= 1'b0;
         end
         if (|s_ev) begin
            event_valid <= 1'b1;
            event_eq    <= s_eqn[commit_queue];
            event_cq    <= commit_queue;
         end else if (event_ready) begin
            event_valid <= 1'b0;
         end
      end
   end

   a_r8_resp_hold: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && !resp_ready) |=>
         (resp_valid && $stable(resp_tag) && $stable(resp_addr) && $stable(resp_status)));

   a_r9_event_hold: assert property (@(posedge clk) disable iff (rst)
      (event_valid && !event_ready) |=>
         (event_valid && $stable(event_eq) && $stable(event_cq)));

   a_r5_event_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0(s_ev));
endmodule

// File: tb/cq_ring_manager_tb.sv
module cq_ring_manager_tb;
   localparam int QC = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [6:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = 4'hF;
   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;
   logic [1:0]  enq_queue = '0, commit_queue = '0;
   logic [3:0]  enq_tag = '0;
   logic        enq_valid = 0, commit_valid = 0, resp_ready = 1, event_ready = 1;
   logic        enq_ready, resp_valid, commit_ready, event_valid;
   logic [3:0]  resp_tag;
   logic [1:0]  resp_status, event_cq;
   logic [31:0] resp_addr;
   logic [7:0]  event_eq;

   cq_ring_manager u_dut (
      .clk(clk), .rst(rst),
      .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
      .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
      .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
      .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
      .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
      .s_axil_rvalid(rvalid), .s_axil_rready(rready),
      .enq_queue(enq_queue), .enq_tag(enq_tag), .enq_valid(enq_valid), .enq_ready(enq_ready),
      .resp_tag(resp_tag), .resp_status(resp_status), .resp_addr(resp_addr),
      .resp_valid(resp_valid), .resp_ready(resp_ready),
      .commit_queue(commit_queue), .commit_valid(commit_valid), .commit_ready(commit_ready),
      .event_eq(event_eq), .event_cq(event_cq), .event_valid(event_valid),
      .event_ready(event_ready)
   );

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string cur_req = "R1";

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // reference model state
   logic [31:0] m_base [QC];
   logic [3:0]  m_log  [QC];
   logic [7:0]  m_eqn  [QC];
   logic        m_arm  [QC];
   logic [15:0] m_prod [QC], m_cons [QC], m_rsv [QC];
   logic        m_resp_v = 0, m_evt_v = 0, m_bv = 0, m_rv = 0;
   logic [3:0]  m_resp_tag;
   logic [1:0]  m_resp_st, m_evt_cq;
   logic [31:0] m_resp_addr, m_rdata;
   logic [7:0]  m_evt_eq;

   logic        mm_e_rdy, mm_c_rdy, mm_wgo, mm_rgo, mm_res, mm_ret, mm_ev, mm_full;
   logic [1:0]  mm_q, mm_wq, mm_rq;
   logic [2:0]  mm_ww, mm_rw;
   logic [15:0] mm_occ;
   logic [16:0] mm_size;

   function automatic logic [31:0] model_read(logic [1:0] q, logic [2:0] w);
      case (w)
         3'd0: return m_base[q];
         3'd1: return {m_arm[q], 15'd0, m_eqn[q], 4'd0, m_log[q]};
         3'd2: return {16'd0, m_prod[q]};
         3'd3: return {16'd0, m_cons[q]};
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < QC; i++) begin
            m_base[i] = '0; m_log[i] = '0; m_eqn[i] = '0; m_arm[i] = 1'b0;
            m_prod[i] = '0; m_cons[i] = '0; m_rsv[i] = '0;
         end
         m_resp_v = 0; m_evt_v = 0; m_bv = 0; m_rv = 0;
         m_resp_tag = '0; m_resp_st = '0; m_resp_addr = '0; m_rdata = '0;
         m_evt_eq = '0; m_evt_cq = '0;
      end else begin
         mm_e_rdy = !m_resp_v || resp_ready;
         mm_c_rdy = !m_evt_v || event_ready;
         mm_wgo   = awvalid && wvalid && !m_bv;
         mm_rgo   = arvalid && !m_rv;
         mm_rq    = araddr[6:5]; mm_rw = araddr[4:2];
         mm_wq    = awaddr[6:5]; mm_ww = awaddr[4:2];
         if (mm_rgo) begin
            m_rdata = model_read(mm_rq, mm_rw);
            m_rv = 1'b1;
         end else if (rready) m_rv = 1'b0;
         if (mm_wgo) m_bv = 1'b1;
         else if (bready) m_bv = 1'b0;
         mm_res = 1'b0;
         mm_q   = enq_queue;
         if (enq_valid && mm_e_rdy) begin
            mm_occ  = m_prod[mm_q] + m_rsv[mm_q] - m_cons[mm_q];
            mm_size = 17'd1 << m_log[mm_q];
            mm_full = {1'b0, mm_occ} >= mm_size;
            m_resp_v    = 1'b1;
            m_resp_tag  = enq_tag;
            m_resp_st   = mm_full ? 2'd1 : 2'd0;
            m_resp_addr = m_base[mm_q] +
               ({16'd0, (m_prod[mm_q] + m_rsv[mm_q]) & (mm_size[15:0] - 16'd1)} << 5);
            mm_res = !mm_full;
         end else if (resp_ready) m_resp_v = 1'b0;
         mm_ret = commit_valid && mm_c_rdy && (m_rsv[commit_queue] != 16'd0);
         mm_ev  = mm_ret && m_arm[commit_queue];
         if (mm_res) m_rsv[mm_q] = m_rsv[mm_q] + 16'd1;
         if (mm_ret) begin
            m_rsv[commit_queue]  = m_rsv[commit_queue] - 16'd1;
            m_prod[commit_queue] = m_prod[commit_queue] + 16'd1;
         end
         if (mm_ev) begin
            m_evt_v  = 1'b1;
            m_evt_eq = m_eqn[commit_queue];
            m_evt_cq = commit_queue;
            m_arm[commit_queue] = 1'b0;
         end else if (event_ready) m_evt_v = 1'b0;
         if (mm_wgo && wstrb == 4'hF) begin
            case (mm_ww)
               3'd0: m_base[mm_wq] = wdata;
               3'd1: begin
                  m_log[mm_wq] = wdata[3:0];
                  m_eqn[mm_wq] = wdata[15:8];
                  m_arm[mm_wq] = wdata[31];
               end
               3'd3: m_cons[mm_wq] = wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the edge
   always @(negedge clk) begin
      #1;
      if (!rst) begin
         chk("enq_ready", 32'(enq_ready), 32'(!m_resp_v || resp_ready));
         chk("resp_valid", 32'(resp_valid), 32'(m_resp_v));
         if (m_resp_v) begin
            chk("resp_tag", 32'(resp_tag), 32'(m_resp_tag));
            chk("resp_status", 32'(resp_status), 32'(m_resp_st));
            if (m_resp_st == 2'd0) chk("resp_addr", resp_addr, m_resp_addr);
         end
         chk("commit_ready", 32'(commit_ready), 32'(!m_evt_v || event_ready));
         chk("event_valid", 32'(event_valid), 32'(m_evt_v));
         if (m_evt_v) begin
            chk("event_eq", 32'(event_eq), 32'(m_evt_eq));
            chk("event_cq", 32'(event_cq), 32'(m_evt_cq));
         end
         chk("bvalid", 32'(bvalid), 32'(m_bv));
         chk("rvalid", 32'(rvalid), 32'(m_rv));
         if (m_rv) chk("rdata", rdata, m_rdata);
      end
   end

   task automatic axw(logic [1:0] q, logic [2:0] w, logic [31:0] d, logic [3:0] s = 4'hF);
      @(negedge clk);
      awaddr = {q, w, 2'b00}; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      #1;
      while (!awready) begin @(negedge clk); #1; end
      @(negedge clk);
      awvalid = 0; wvalid = 0; wstrb = 4'hF;
   endtask

   task automatic axr(logic [1:0] q, logic [2:0] w);
      @(negedge clk);
      araddr = {q, w, 2'b00}; arvalid = 1;
      #1;
      while (!arready) begin @(negedge clk); #1; end
      @(negedge clk);
      arvalid = 0;
   endtask

   task automatic enq(logic [1:0] q, logic [3:0] t);
      @(negedge clk);
      enq_queue = q; enq_tag = t; enq_valid = 1;
      #1;
      while (!enq_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      enq_valid = 0;
   endtask

   task automatic cmt(logic [1:0] q);
      @(negedge clk);
      commit_queue = q; commit_valid = 1;
      #1;
      while (!commit_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      commit_valid = 0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 0;
      cur_req = "R1";
      repeat (2) @(negedge clk);
      axr(2'd0, 3'd2);
      axr(2'd0, 3'd1);

      cur_req = "R6";
      axw(2'd0, 3'd0, 32'h1000_0000);
      axw(2'd0, 3'd1, 32'h0000_0502);
      axw(2'd1, 3'd0, 32'h2000_0100);
      axw(2'd1, 3'd1, 32'h8000_0703);
      axr(2'd0, 3'd0); axr(2'd0, 3'd1); axr(2'd1, 3'd1);
      axw(2'd0, 3'd2, 32'h0000_0077);
      axr(2'd0, 3'd2);
      axr(2'd0, 3'd5);

      cur_req = "R2";
      enq(2'd0, 4'd1);
      enq(2'd0, 4'd2);

      cur_req = "R3";
      enq(2'd0, 4'd3);
      enq(2'd0, 4'd4);
      enq(2'd0, 4'd5);

      cur_req = "R4";
      cmt(2'd0); cmt(2'd0);
      axr(2'd0, 3'd2);
      cmt(2'd2);
      axr(2'd2, 3'd2);

      cur_req = "R7";
      enq(2'd0, 4'd6);
      axw(2'd0, 3'd3, 32'd2);
      enq(2'd0, 4'd7);
      axr(2'd0, 3'd3);

      cur_req = "R5";
      enq(2'd1, 4'd8); cmt(2'd1);
      axr(2'd1, 3'd1);
      enq(2'd1, 4'd9); cmt(2'd1);
      axw(2'd1, 3'd1, 32'h8000_0703);
      enq(2'd1, 4'd10); cmt(2'd1);
      axr(2'd1, 3'd2);

      cur_req = "R8";
      @(negedge clk);
      resp_ready = 0; enq_queue = 2'd1; enq_tag = 4'd11; enq_valid = 1;
      @(negedge clk);
      enq_tag = 4'd12;
      repeat (3) @(negedge clk);
      resp_ready = 1;
      @(negedge clk);
      enq_valid = 0;
      repeat (2) @(negedge clk);

      cur_req = "R9";
      axw(2'd1, 3'd1, 32'h8000_0703);
      @(negedge clk);
      event_ready = 0; commit_queue = 2'd1; commit_valid = 1;
      @(negedge clk);
      repeat (3) @(negedge clk);
      event_ready = 1;
      @(negedge clk);
      commit_valid = 0;
      repeat (2) @(negedge clk);
      axr(2'd1, 3'd2);

      cur_req = "R10";
      axw(2'd3, 3'd0, 32'hDEAD_BEEF, 4'h3);
      axr(2'd3, 3'd0);
      axw(2'd3, 3'd1, 32'h8000_0000, 4'h8);
      axr(2'd3, 3'd1);

      cur_req = "R3";
      axw(2'd3, 3'd3, 32'h0000_FFFF);
      enq(2'd3, 4'd13);
      cur_req = "R7";
      axw(2'd3, 3'd3, 32'h0000_0000);
      enq(2'd3, 4'd14);
      cmt(2'd3);
      enq(2'd3, 4'd15);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule